// File: doc/BRIEF.md
# Random-Number Generator Register and Status Front End

This block is the software-visible face of a hardware random-number generator. It sits on a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). It holds the generator's control and tuning registers, and it presents the most recent 128-bit random result as four 32-bit words. It collects pulses from the health-test logic into sticky status flags and raises a single interrupt line.

Random blocks arrive from the entropy source over a valid/ready handshake. The block accepts a result only while the generator is enabled and no unread result is pending. Software reads the four words, then writes one to the ready flag. That write releases the handshake, so the next block can land. Each of the seven health events has its own sticky flag and its own interrupt enable. A flag is cleared by writing one to it.

Top module: `trng_csr`

## Requirements
- R1: After reset every writable register reads zero, the status register reads zero, `src_ready` and `irq` are low, and the revision register at 0x7C reads major in bits 27:24, minor in 23:20 and patch in 19:16 (defaults 2, 3, 4, giving 0x02340000).
- R2: `src_ready` is high only while control bit 10 (generator enable) is set and status bit 0 (ready) is clear. A block is taken when `src_valid` and `src_ready` are both high at a clock edge.
- R3: Taking a block stores it: bits 31:0 appear at 0x00, 63:32 at 0x04, 95:64 at 0x08 and 127:96 at 0x0C. The stored words stay unchanged while ready is set, whatever the source presents.
- R4: Taking a block sets status bit 0 in the following cycle. Writing 1 to bit 0 of the status register (0x10) clears it, and the next offered block is then taken.
- R5: Event input `fail_evt[k]` sets status bit k+1, for k = 0..6: bit 1 shutdown overflow, 2 stuck output, 3 noise, 4 run, 5 long run, 6 poker, 7 monobit. The flag stays set until 1 is written to that bit, and writing 0 to a bit leaves it unchanged.
- R6: When an event pulse and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when some status bit n in 7:1 is set while control bit n is set. The ready bit never raises `irq`.
- R8: Control (0x14) keeps only bits 10 and 7:1. Configuration (0x18) keeps bits 31:16 (maximum refill cycles) and 7:0 (minimum refill cycles). Alarm count (0x1C) keeps bits 7:0 (threshold). All other bits in these three registers read zero.
- R9: The oscillator enable (0x20), detune (0x24), alarm mask (0x28) and alarm stop (0x2C) registers store and return all 32 bits.
- R10: The revision (0x7C) and options (0x78, default value 0) registers are read-only. Writes to them have no effect.
- R11: Writes to the data words 0x00..0x0C have no effect on what they return.
- R12: Reads from addresses with no register return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_valid | input | 1 | Entropy source offers a block |
| src_data | input | 128 | Offered random block |
| src_ready | output | 1 | Block will be taken at the next edge if offered |
| fail_evt | input | 7 | Health-test event pulses; bit k maps to status bit k+1 |
| irq | output | 1 | Level interrupt from enabled event flags |

## Verification
The hardest case to reach is a health-test pulse and a software clear of the same flag in one clock cycle. Two independent sources, the event input and the bus, must line up on one edge. The bench therefore drives both from the same task, at the same falling edge, and then reads the flag back.

The second difficult case is the refill ordering. The source is kept offering a different block the whole time a result is pending. This shows that the stored words stay frozen, and that the new block lands exactly one edge after the ready clear.

// File: rtl/trng_csr_pkg.sv
package trng_csr_pkg;

  localparam int unsigned WORD_W = 32;

  // word-aligned register offsets (byte addresses)
  localparam int unsigned OFS_STAT   = 'h10;
  localparam int unsigned OFS_CTRL   = 'h14;
  localparam int unsigned OFS_CFG    = 'h18;
  localparam int unsigned OFS_ALM    = 'h1C;
  localparam int unsigned OFS_OSCEN  = 'h20;
  localparam int unsigned OFS_DETUNE = 'h24;
  localparam int unsigned OFS_AMASK  = 'h28;
  localparam int unsigned OFS_ASTOP  = 'h2C;
  localparam int unsigned OFS_OPT    = 'h78;
  localparam int unsigned OFS_REV    = 'h7C;

  localparam int unsigned CTRL_EN_BIT = 10;

  // bits of each register that store state
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h0000_04FE;
  localparam logic [WORD_W-1:0] CFG_KEEP  = 32'hFFFF_00FF;
  localparam logic [WORD_W-1:0] ALM_KEEP  = 32'h0000_00FF;

  localparam int unsigned N_TUNE = 4;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_CFG,
    SEL_ALM,
    SEL_TUNE,
    SEL_OPT,
    SEL_REV
  } reg_sel_e;

endpackage

// File: rtl/trng_cfg_regs.sv
module trng_cfg_regs
  import trng_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [1:0]        tune_idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] cfg_q,
  output logic [WORD_W-1:0] alm_q,
  output logic [WORD_W-1:0] tune_q [N_TUNE]
);

  logic [WORD_W-1:0] ctrl_d, cfg_d, alm_d;
  logic              ctrl_ce, cfg_ce, alm_ce;

  always_comb begin
    ctrl_ce = wr_en && (sel == SEL_CTRL);
    cfg_ce  = wr_en && (sel == SEL_CFG);
    alm_ce  = wr_en && (sel == SEL_ALM);
    ctrl_d  = wdata & CTRL_KEEP;
    cfg_d   = wdata & CFG_KEEP;
    alm_d   = wdata & ALM_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      alm_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (cfg_ce)  cfg_q  <= cfg_d;
      if (alm_ce)  alm_q  <= alm_d;
    end
  end

  // four full-width oscillator tuning registers
  for (genvar g = 0; g < N_TUNE; g++) begin : g_tune
    logic tune_ce;
    always_comb tune_ce = wr_en && (sel == SEL_TUNE) && (tune_idx == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tune_q[g] <= '0;
      else if (tune_ce) tune_q[g] <= wdata;
    end
  end

  p_ctrl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_KEEP) == '0);

endmodule

// File: rtl/trng_evt_status.sv
module trng_evt_status #(
  parameter int unsigned N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic             clr_wr,
  input  logic [N_EVT-1:0] clr_mask,
  input  logic [N_EVT-1:0] irq_en,
  output logic [N_EVT-1:0] flags_q,
  output logic             irq
);

  logic [N_EVT-1:0] flags_d;

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    // an arriving event outranks a same-cycle clear
    always_comb flags_d[i] = evt_pulse[i] | (flags_q[i] & ~(clr_wr & clr_mask[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end

    p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[i] |=> flags_q[i]);

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[i] && !evt_pulse[i]) |=> !flags_q[i]);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !(clr_wr && clr_mask[i])) |=> flags_q[i]);
  end

  always_comb irq = |(flags_q & irq_en);

endmodule

// File: rtl/trng_data_hold.sv
module trng_data_hold #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        gen_en,
  input  logic                        src_valid,
  input  logic [WORD_W*N_WORDS-1:0]   src_data,
  input  logic                        ack_wr,
  output logic                        src_ready,
  output logic                        ready_q,
  output logic [WORD_W*N_WORDS-1:0]   words_q
);

  logic accept;
  logic ready_d;

  always_comb begin
    src_ready = gen_en & ~ready_q;
    accept    = src_valid & src_ready;
    if (accept)      ready_d = 1'b1;
    else if (ack_wr) ready_d = 1'b0;
    else             ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      words_q[w*WORD_W +: WORD_W] <= '0;
      else if (accept) words_q[w*WORD_W +: WORD_W] <= src_data[w*WORD_W +: WORD_W];
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> $stable(words_q));

  p_ready_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(src_valid && src_ready));

endmodule

// File: rtl/trng_csr.sv
module trng_csr
  import trng_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned N_WORDS     = 4,
  parameter int unsigned N_EVT       = 7,
  parameter int unsigned REV_MAJOR   = 2,
  parameter int unsigned REV_MINOR   = 3,
  parameter int unsigned REV_PATCH   = 4,
  parameter logic [31:0] OPTIONS_VAL = 32'h0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic                        src_valid,
  input  logic [WORD_W*N_WORDS-1:0]   src_data,
  output logic                        src_ready,
  input  logic [N_EVT-1:0]            fail_evt,
  output logic                        irq
);

  localparam int unsigned WA_W = ADDR_W - 2;
  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [WORD_W-1:0] REV_VAL =
    {4'h0, 4'(REV_MAJOR), 4'(REV_MINOR), 4'(REV_PATCH), 16'h0};

  logic [WA_W-1:0]             word_addr;
  reg_sel_e                    sel;
  logic [1:0]                  tune_idx;
  logic [IDX_W-1:0]            data_idx;
  logic [WORD_W-1:0]           ctrl_q, cfg_q, alm_q;
  logic [WORD_W-1:0]           tune_q [N_TUNE];
  logic                        stat_wr;
  logic                        ready_q;
  logic [WORD_W*N_WORDS-1:0]   words_q;
  logic [N_EVT-1:0]            flags_q;
  logic [N_EVT-1:0]            irq_en;
  logic                        gen_en;
  logic [WORD_W-1:0]           stat_view;

  // address decode
  always_comb begin
    word_addr = bus_addr[ADDR_W-1:2];
    tune_idx  = bus_addr[3:2];
    data_idx  = bus_addr[IDX_W+1:2];
    if (32'(word_addr) < N_WORDS)                    sel = SEL_DATA;
    else if (32'(word_addr) == OFS_STAT >> 2)        sel = SEL_STAT;
    else if (32'(word_addr) == OFS_CTRL >> 2)        sel = SEL_CTRL;
    else if (32'(word_addr) == OFS_CFG >> 2)         sel = SEL_CFG;
    else if (32'(word_addr) == OFS_ALM >> 2)         sel = SEL_ALM;
    else if ((32'(word_addr) >= OFS_OSCEN >> 2) &&
             (32'(word_addr) <= OFS_ASTOP >> 2))     sel = SEL_TUNE;
    else if (32'(word_addr) == OFS_OPT >> 2)         sel = SEL_OPT;
    else if (32'(word_addr) == OFS_REV >> 2)         sel = SEL_REV;
    else                                             sel = SEL_NONE;
  end

  always_comb begin
    stat_wr = bus_we && (sel == SEL_STAT);
    gen_en  = ctrl_q[CTRL_EN_BIT];
    irq_en  = ctrl_q[N_EVT:1];
  end

  trng_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_we),
    .sel      (sel),
    .tune_idx (tune_idx),
    .wdata    (bus_wdata),
    .ctrl_q   (ctrl_q),
    .cfg_q    (cfg_q),
    .alm_q    (alm_q),
    .tune_q   (tune_q)
  );

  trng_data_hold #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .src_valid (src_valid),
    .src_data  (src_data),
    .ack_wr    (stat_wr && bus_wdata[0]),
    .src_ready (src_ready),
    .ready_q   (ready_q),
    .words_q   (words_q)
  );

  trng_evt_status #(.N_EVT(N_EVT)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (fail_evt),
    .clr_wr    (stat_wr),
    .clr_mask  (bus_wdata[N_EVT:1]),
    .irq_en    (irq_en),
    .flags_q   (flags_q),
    .irq       (irq)
  );

  // read mux
  always_comb begin
    stat_view = '0;
    stat_view[N_EVT:0] = {flags_q, ready_q};
    case (sel)
      SEL_DATA: bus_rdata = words_q[32'(data_idx)*WORD_W +: WORD_W];
      SEL_STAT: bus_rdata = stat_view;
      SEL_CTRL: bus_rdata = ctrl_q;
      SEL_CFG:  bus_rdata = cfg_q;
      SEL_ALM:  bus_rdata = alm_q;
      SEL_TUNE: bus_rdata = tune_q[tune_idx];
      SEL_OPT:  bus_rdata = OPTIONS_VAL;
      SEL_REV:  bus_rdata = REV_VAL;
      default:  bus_rdata = '0;
    endcase
  end

  p_no_take_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !src_ready);

  p_no_take_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !src_ready);

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

endmodule

// File: tb/tb_trng_csr.sv
module tb_trng_csr;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   bus_addr;
  logic         bus_we;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         src_valid;
  logic [127:0] src_data;
  logic         src_ready;
  logic [6:0]   fail_evt;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trng_csr dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .fail_evt(fail_evt), .irq(irq)
  );

  // {addr, write data, expected read-back}
  localparam logic [71:0] TBL [12] = '{
    {8'h14, 32'hFFFF_FFFF, 32'h0000_04FE},  // R8
    {8'h18, 32'hFFFF_FFFF, 32'hFFFF_00FF},  // R8
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_00FF},  // R8
    {8'h20, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R9
    {8'h24, 32'h1234_5678, 32'h1234_5678},  // R9
    {8'h28, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R9
    {8'h2C, 32'h0F0F_0F0F, 32'h0F0F_0F0F},  // R9
    {8'h7C, 32'hFFFF_FFFF, 32'h0234_0000},  // R10
    {8'h78, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},  // R12
    {8'h14, 32'h0000_0000, 32'h0000_0000}   // R8
  };

  localparam logic [127:0] BLK_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] BLK_B = 128'hCAFE_F00D_1111_2222_3333_4444_5555_6666;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    fail_evt = e;
    @(posedge clk); #1;
    fail_evt = '0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    src_valid = 1'b0; src_data = '0; fail_evt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, 32'h0, "R1 status");
    rd(8'h14, 32'h0, "R1 ctrl");
    rd(8'h18, 32'h0, "R1 cfg");
    rd(8'h2C, 32'h0, "R1 alarm stop");
    rd(8'h7C, 32'h0234_0000, "R1 revision");
    check("R1 src_ready", {31'h0, src_ready}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // register table
    for (int i = 0; i < 12; i++) begin
      wr(TBL[i][71:64], TBL[i][63:32]);
      rd(TBL[i][71:64], TBL[i][31:0], "R8 R9 R10 R11 R12 table");
    end

    // R2: offer while disabled
    @(negedge clk); src_valid = 1'b1; src_data = BLK_A;
    repeat (3) @(posedge clk); #1;
    check("R2 ready while disabled", {31'h0, src_ready}, 32'h0);
    rd(8'h10, 32'h0, "R2 nothing taken while disabled");

    wr(8'h14, 32'h0000_0400);
    check("R2 ready once enabled", {31'h0, src_ready}, 32'h1);
    @(posedge clk); #1;
    rd(8'h10, 32'h1, "R4 ready set after take");
    check("R2 ready low while pending", {31'h0, src_ready}, 32'h0);
    rd(8'h00, BLK_A[31:0],   "R3 word0");
    rd(8'h04, BLK_A[63:32],  "R3 word1");
    rd(8'h08, BLK_A[95:64],  "R3 word2");
    rd(8'h0C, BLK_A[127:96], "R3 word3");

    // R3 hold while pending, R11 write ignored
    @(negedge clk); src_data = BLK_B;
    repeat (3) @(posedge clk); #1;
    rd(8'h08, BLK_A[95:64], "R3 held while ready");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, BLK_A[31:0], "R11 data write ignored");

    // R5 writing zero keeps ready
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h1, "R5 write zero no effect");

    // R4 clear ready releases next block
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h0, "R4 ready cleared");
    @(posedge clk); #1;
    rd(8'h10, 32'h1, "R4 next block taken");
    rd(8'h0C, BLK_B[127:96], "R4 new word3");
    rd(8'h00, BLK_B[31:0],   "R4 new word0");
    @(negedge clk); src_valid = 1'b0;

    // R7 interrupt gating
    check("R7 ready alone no irq", {31'h0, irq}, 32'h0);
    pulse(7'b000_0001);
    rd(8'h10, 32'h3, "R5 shutdown flag");
    check("R7 masked event no irq", {31'h0, irq}, 32'h0);
    wr(8'h14, 32'h0000_0402);
    check("R7 enabled event irq", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h2);
    rd(8'h10, 32'h1, "R5 flag cleared");
    check("R7 irq drops", {31'h0, irq}, 32'h0);

    // R5 each event to its bit
    wr(8'h14, 32'h0000_04FE);
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k));
      rd(8'h10, 32'h1 | (32'h2 << k), "R5 event bit");
      check("R7 irq per event", {31'h0, irq}, 32'h1);
      wr(8'h10, 32'h2 << k);
      rd(8'h10, 32'h1, "R5 event cleared");
    end

    // R6 set beats clear in same cycle
    @(negedge clk);
    fail_evt = 7'b100_0000;
    bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'h80;
    @(posedge clk); #1;
    fail_evt = '0; bus_we = 1'b0;
    rd(8'h10, 32'h81, "R6 set wins");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h81, "R5 zero write keeps flag");
    wr(8'h10, 32'h80);
    rd(8'h10, 32'h01, "R6 later clear works");

    finish_run();
  end

endmodule